// File: doc/BRIEF.md
# Dual-Button Long-Push Reset and Power-Off Detector

This block watches two active-low push-buttons, a power button and a dedicated reset button, while the system is in normal operation. When both are held down together for long enough, it declares a long push, which lets a user recover a hung processor. The hold time is the sum of a fixed debounce interval, a fixed minimum interrupt width and an extra delay that is set at run time as a cycle count. The extra delay may be zero.

An elaboration-time mode picks what a long push does. In reset mode the block drives an active-low reset request for a recovery interval. It then opens a confirmation window, and the processor must hold its confirm line high by the end of that window or an enable-off request is raised. In enable-off mode the long push raises the enable-off request at once.

The same hold-time rule applies to the undervoltage input. A sustained undervoltage raises the enable-off request. While the run input is low, the block is idle and all of its timers are cleared.

Top module: `longpush_guard`

## Requirements
- R1: After reset, `long_push_o` is 0, `rst_n_o` is 1 and `en_off_o` is 0.
- R2: Let T be `DEB_CYC + INTMIN_CYC + xdly_i`. Both buttons must read low (0 = pressed) on T+1 consecutive rising clock edges. `long_push_o` is then high for exactly one cycle, directly after the (T+1)-th edge, and it does not rise again until the hold is broken.
- R3: The buttons may be pressed in either order, and cycles with only one button pressed do not count. Timing starts at the first edge on which both are pressed.
- R4: With `xdly_i` = 0, T is `DEB_CYC + INTMIN_CYC`.
- R5: If either button is released before the (T+1)-th edge, no output changes and the count restarts from zero.
- R6: The reset button counts only after it has been seen released (1) while `run_i` is high. A reset button that is already held when `run_i` rises cannot take part until it has been released.
- R7: In reset mode (`MODE` = RESP_RESET), `rst_n_o` goes low on the cycle after the `long_push_o` pulse and stays low for exactly `REC_CYC` cycles. The long push itself does not raise `en_off_o`.
- R8: In reset mode, a confirmation window of `BLANK_CYC` cycles follows the reset release. If `hold_cfm_i` is 0 on the window's last cycle, `en_off_o` pulses for one cycle, `REC_CYC + BLANK_CYC + 1` cycles after the long-push pulse. If it is 1, there is no pulse.
- R9: In enable-off mode (`MODE` = RESP_ENABLE_OFF), `en_off_o` pulses in the same cycle as `long_push_o`, and `rst_n_o` stays 1.
- R10: `uv_i` high on T+1 consecutive edges raises a one-cycle `en_off_o` pulse after the (T+1)-th edge, in both modes. A run of only T edges has no effect.
- R11: While `run_i` is 0, no output pulses, and the timers and the reset sequence are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | High during normal operation; low idles the block |
| pwr_btn_n | input | 1 | Power button, active low |
| rst_btn_n | input | 1 | Reset button, active low |
| uv_i | input | 1 | Undervoltage flag, active high |
| hold_cfm_i | input | 1 | Processor confirm line, sampled at the end of the window |
| xdly_i | input | DLY_W | Extra hold delay in cycles |
| long_push_o | output | 1 | One-cycle long-push event |
| rst_n_o | output | 1 | Active-low reset request |
| en_off_o | output | 1 | One-cycle enable-off request |

## Verification
The hold counters can hold a wrong value, for example if they fail to clear on release or fail to saturate after firing. That shows up as a long-push or enable-off pulse on the wrong edge, or as a second pulse during one hold, within T+1 cycles of the stimulus. The bench measures the exact edge index of every pulse. A wrong state in the reset sequencer shows up as a wrong count of low cycles on `rst_n_o`, or as an enable-off pulse that is misplaced or missing, within `REC_CYC + BLANK_CYC + 1` cycles of the long push. A stale reset-button qualifier lets a pre-held button trigger a long push after about T cycles, and the bench sets up exactly that case.

// File: rtl/longpush_pkg.sv
package longpush_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_RECOV  = 2'd1,
        SEQ_WINDOW = 2'd2
    } seq_state_e;

    typedef enum logic {
        RESP_ENABLE_OFF = 1'b0,
        RESP_RESET      = 1'b1
    } resp_mode_e;

    typedef struct packed {
        logic long_push;
        logic rst_n;
        logic en_off;
    } guard_out_t;

    // Counter width able to hold the largest limit plus one saturation step.
    function automatic int unsigned hold_cnt_width(int unsigned deb,
                                                   int unsigned imin,
                                                   int unsigned dly_w);
        return $clog2(deb + imin + (1 << dly_w) + 1) + 1;
    endfunction

    function automatic int unsigned span_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lp_btn_qual.sv
module lp_btn_qual (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic btn_n_i,
    output logic qual_o
);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            qual_o <= 1'b0;
        end else if (btn_n_i) begin
            qual_o <= 1'b1;
        end
    end

    // R6: the qualifier only arms after the button was seen released
    p_qual_needs_release_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(qual_o) |-> $past(btn_n_i));

endmodule

// File: rtl/lp_hold_timer.sv
module lp_hold_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cond_i,
    input  logic [CW-1:0] limit_i,
    output logic          fire_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            fire_o <= 1'b0;
        end else begin
            fire_o <= cond_i && (cnt_q == limit_i);
            if (!cond_i) begin
                cnt_q <= '0;
            end else if (cnt_q <= limit_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2: a pulse needs the condition on the edge that produced it
    p_fire_cond_r2: assert property (@(posedge clk) disable iff (rst)
        fire_o |-> $past(cond_i));

    // R2: one pulse per sustained hold
    p_fire_once_r2: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> !fire_o);

endmodule

// File: rtl/lp_rst_seq.sv
module lp_rst_seq
    import longpush_pkg::*;
#(
    parameter int unsigned REC_CYC   = 5,
    parameter int unsigned BLANK_CYC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic start_i,
    input  logic hold_cfm_i,
    output logic rst_n_o,
    output logic off_o
);

    localparam int unsigned SPAN = (REC_CYC > BLANK_CYC) ? REC_CYC : BLANK_CYC;
    localparam int unsigned SW   = span_width(SPAN);
    localparam logic [SW-1:0] REC_LAST   = SW'(REC_CYC - 1);
    localparam logic [SW-1:0] BLANK_LAST = SW'(BLANK_CYC - 1);

    seq_state_e    state_q;
    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            off_o   <= 1'b0;
        end else begin
            off_o <= 1'b0;
            if (start_i) begin
                state_q <= SEQ_RECOV;
                cnt_q   <= '0;
            end else begin
                unique case (state_q)
                    SEQ_RECOV: begin
                        if (cnt_q == REC_LAST) begin
                            state_q <= SEQ_WINDOW;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    SEQ_WINDOW: begin
                        if (cnt_q == BLANK_LAST) begin
                            state_q <= SEQ_IDLE;
                            cnt_q   <= '0;
                            off_o   <= !hold_cfm_i;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    assign rst_n_o = (state_q != SEQ_RECOV);

    // R7: a started sequence pulls the reset request low on the next cycle
    p_recov_follows_push_r7: assert property (@(posedge clk) disable iff (rst)
        (start_i && run_i) |=> !rst_n_o);

    // R8: the enable-off request comes only from an unconfirmed window end
    p_off_from_window_r8: assert property (@(posedge clk) disable iff (rst)
        off_o |-> $past(state_q == SEQ_WINDOW && !hold_cfm_i));

endmodule

// File: rtl/longpush_guard.sv
module longpush_guard
    import longpush_pkg::*;
#(
    parameter int unsigned DEB_CYC    = 3,
    parameter int unsigned INTMIN_CYC = 4,
    parameter int unsigned DLY_W      = 4,
    parameter int unsigned REC_CYC    = 5,
    parameter int unsigned BLANK_CYC  = 6,
    parameter resp_mode_e  MODE       = RESP_RESET
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             pwr_btn_n,
    input  logic             rst_btn_n,
    input  logic             uv_i,
    input  logic             hold_cfm_i,
    input  logic [DLY_W-1:0] xdly_i,
    output logic             long_push_o,
    output logic             rst_n_o,
    output logic             en_off_o
);

    localparam int unsigned CW = hold_cnt_width(DEB_CYC, INTMIN_CYC, DLY_W);
    localparam logic [CW-1:0] BASE_LIMIT = CW'(DEB_CYC + INTMIN_CYC);

    logic          rst_qual;
    logic          both_held;
    logic          uv_run;
    logic [CW-1:0] limit;
    logic          push_fire;
    logic          uv_fire;
    guard_out_t    outs;

    lp_btn_qual u_qual (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run_i),
        .btn_n_i (rst_btn_n),
        .qual_o  (rst_qual)
    );

    assign limit     = BASE_LIMIT + CW'(xdly_i);
    assign both_held = run_i && rst_qual && !pwr_btn_n && !rst_btn_n;
    assign uv_run    = run_i && uv_i;

    lp_hold_timer #(.CW(CW)) u_push_tmr (
        .clk     (clk),
        .rst     (rst),
        .cond_i  (both_held),
        .limit_i (limit),
        .fire_o  (push_fire)
    );

    lp_hold_timer #(.CW(CW)) u_uv_tmr (
        .clk     (clk),
        .rst     (rst),
        .cond_i  (uv_run),
        .limit_i (limit),
        .fire_o  (uv_fire)
    );

    generate
        if (MODE == RESP_RESET) begin : g_reset_resp
            logic seq_rst_n;
            logic seq_off;

            lp_rst_seq #(
                .REC_CYC   (REC_CYC),
                .BLANK_CYC (BLANK_CYC)
            ) u_seq (
                .clk        (clk),
                .rst        (rst),
                .run_i      (run_i),
                .start_i    (push_fire),
                .hold_cfm_i (hold_cfm_i),
                .rst_n_o    (seq_rst_n),
                .off_o      (seq_off)
            );

            assign outs.rst_n  = seq_rst_n;
            assign outs.en_off = seq_off || uv_fire;
        end else begin : g_enoff_resp
            assign outs.rst_n  = 1'b1;
            assign outs.en_off = push_fire || uv_fire;
        end
    endgenerate

    assign outs.long_push = push_fire;

    assign long_push_o = outs.long_push;
    assign rst_n_o     = outs.rst_n;
    assign en_off_o    = outs.en_off;

    // R3: a long push needs both buttons pressed on the deciding edge
    p_push_both_r3: assert property (@(posedge clk) disable iff (rst)
        long_push_o |-> $past(!pwr_btn_n && !rst_btn_n));

    // R11: no enable-off request unless running on the previous edge
    p_off_needs_run_r11: assert property (@(posedge clk) disable iff (rst)
        en_off_o |-> $past(run_i));

endmodule

// File: tb/test_longpush_guard.sv
module test_longpush_guard;
    import longpush_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEB = 3;
    localparam int IMIN = 4;
    localparam int REC = 5;
    localparam int BLANK = 6;

    // vector: dly[21:18] order[17:16] lead[15:12] hold[11:6] expected fire index[5:0] (0 = none)
    // order: 0 both together, 1 power button first, 2 reset button first
    localparam int NV = 8;
    localparam logic [21:0] VEC [NV] = '{
        {4'd0,  2'd0, 4'd0, 6'd10, 6'd8},   // R4
        {4'd3,  2'd0, 4'd0, 6'd14, 6'd11},  // R2
        {4'd3,  2'd0, 4'd0, 6'd10, 6'd0},   // R5
        {4'd3,  2'd0, 4'd0, 6'd11, 6'd11},  // R2 boundary
        {4'd5,  2'd1, 4'd6, 6'd15, 6'd13},  // R3
        {4'd5,  2'd2, 4'd9, 6'd15, 6'd13},  // R3
        {4'd0,  2'd0, 4'd0, 6'd7,  6'd0},   // R5 boundary
        {4'd15, 2'd0, 4'd0, 6'd25, 6'd23}   // R2 max delay
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic pwr_n = 1'b1;
    logic rbtn_n = 1'b1;
    logic uv = 1'b0;
    logic cfm = 1'b1;
    logic [3:0] xdly = 4'd0;
    logic lp_r, rn_r, off_r, lp_e, rn_e, off_e;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    longpush_guard #(.DEB_CYC(DEB), .INTMIN_CYC(IMIN), .DLY_W(4), .REC_CYC(REC),
                     .BLANK_CYC(BLANK), .MODE(RESP_RESET)) i_longpush_guard (
        .clk(clk), .rst(rst), .run_i(run), .pwr_btn_n(pwr_n), .rst_btn_n(rbtn_n),
        .uv_i(uv), .hold_cfm_i(cfm), .xdly_i(xdly),
        .long_push_o(lp_r), .rst_n_o(rn_r), .en_off_o(off_r));

    longpush_guard #(.DEB_CYC(DEB), .INTMIN_CYC(IMIN), .DLY_W(4), .REC_CYC(REC),
                     .BLANK_CYC(BLANK), .MODE(RESP_ENABLE_OFF)) i_longpush_guard_enmode (
        .clk(clk), .rst(rst), .run_i(run), .pwr_btn_n(pwr_n), .rst_btn_n(rbtn_n),
        .uv_i(uv), .hold_cfm_i(cfm), .xdly_i(xdly),
        .long_push_o(lp_e), .rst_n_o(rn_e), .en_off_o(off_e));

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual cycles %0d expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        pwr_n = 1'b1;
        rbtn_n = 1'b1;
        uv = 1'b0;
        for (int i = 0; i < n; i++) step();
    endtask

    // press both, return index of first long_push on the reset instance
    task automatic hold_both(input int hold, output int first, output int pulses);
        first = 0;
        pulses = 0;
        pwr_n = 1'b0;
        rbtn_n = 1'b0;
        for (int i = 1; i <= hold; i++) begin
            step();
            if (lp_r) begin
                if (first == 0) first = i;
                pulses++;
            end
        end
    endtask

    initial begin
        int first, pulses, n, bad;
        repeat (3) @(negedge clk);
        check(lp_r == 1'b0 && rn_r == 1'b1 && off_r == 1'b0, "R1 reset-mode outputs",
              {lp_r, rn_r, off_r}, 3'b010);
        check(lp_e == 1'b0 && rn_e == 1'b1 && off_e == 1'b0, "R1 enable-mode outputs",
              {lp_e, rn_e, off_e}, 3'b010);
        rst = 1'b0;
        run = 1'b1;
        idle(3);

        // table walk
        for (int v = 0; v < NV; v++) begin
            xdly = VEC[v][21:18];
            bad = 0;
            if (VEC[v][17:16] == 2'd1) pwr_n = 1'b0;
            if (VEC[v][17:16] == 2'd2) rbtn_n = 1'b0;
            for (int i = 0; i < int'(VEC[v][15:12]); i++) begin
                step();
                if (lp_r || lp_e) bad++;
            end
            hold_both(int'(VEC[v][11:6]), first, pulses);
            idle(20);
            check(bad == 0, "R3 single button does not count", bad, 0);
            check(first == int'(VEC[v][5:0]), "R2/R3/R4/R5 fire index", first, int'(VEC[v][5:0]));
            check(pulses == ((VEC[v][5:0] != 0) ? 1 : 0), "R2 pulse count", pulses,
                  (VEC[v][5:0] != 0) ? 1 : 0);
        end

        // R7: reset pulse length and no enable-off in reset mode
        xdly = 4'd0;
        cfm = 1'b1;
        hold_both(8, first, pulses);
        check(first == 8, "R7 trigger", first, 8);
        pwr_n = 1'b1;
        rbtn_n = 1'b1;
        n = 0;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            if (i == 0) check(rn_r == 1'b1, "R7 reset high during pulse cycle", rn_r, 1);
            step();
            if (!rn_r) n++;
            if (off_r) bad++;
        end
        check(n == REC, "R7 reset low cycles", n, REC);
        check(bad == 0, "R7 no enable-off with confirm high", bad, 0);

        // R8 and R9: unconfirmed window
        cfm = 1'b0;
        pwr_n = 1'b0;
        rbtn_n = 1'b0;
        first = 0;
        bad = 0;
        for (int i = 1; i <= 8; i++) begin
            step();
            if (lp_e && !off_e) bad++;
            if (!lp_e && off_e) bad++;
            if (!rn_e) bad++;
        end
        check(lp_r == 1'b1, "R8 trigger", lp_r, 1);
        check(bad == 0, "R9 enable-off coincides with long push, reset stays high", bad, 0);
        check(off_r == 1'b0, "R7 long push alone gives no enable-off", off_r, 0);
        pwr_n = 1'b1;
        rbtn_n = 1'b1;
        n = 0;
        pulses = 0;
        for (int i = 1; i <= 20; i++) begin
            step();
            if (off_r) begin
                if (n == 0) n = i;
                pulses++;
            end
            if (!rn_e) bad++;
        end
        check(n == REC + BLANK + 1, "R8 enable-off delay", n, REC + BLANK + 1);
        check(pulses == 1, "R8 enable-off width", pulses, 1);
        check(bad == 0, "R9 enable-mode reset stays high", bad, 0);
        cfm = 1'b1;

        // R10: undervoltage, T = 9 with delay 2
        xdly = 4'd2;
        uv = 1'b1;
        n = 0;
        pulses = 0;
        for (int i = 1; i <= 14; i++) begin
            step();
            if (off_e && off_r) begin
                if (n == 0) n = i;
                pulses++;
            end
        end
        idle(3);
        check(n == 10 && pulses == 1, "R10 undervoltage enable-off index", n, 10);
        uv = 1'b1;
        pulses = 0;
        for (int i = 1; i <= 9; i++) begin
            step();
            if (off_e || off_r) pulses++;
        end
        idle(3);
        check(pulses == 0, "R10 short undervoltage ignored", pulses, 0);

        // R6: reset button held before run rises
        xdly = 4'd0;
        run = 1'b0;
        rbtn_n = 1'b0;
        step();
        run = 1'b1;
        pwr_n = 1'b0;
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (lp_r || lp_e) pulses++;
        end
        check(pulses == 0, "R6 pre-held reset button ignored", pulses, 0);
        rbtn_n = 1'b1;
        step();
        hold_both(10, first, pulses);
        idle(20);
        check(first == 8, "R6 released then pressed qualifies", first, 8);

        // R11: not running
        run = 1'b0;
        pwr_n = 1'b0;
        rbtn_n = 1'b0;
        uv = 1'b1;
        pulses = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (lp_r || lp_e || off_r || off_e || !rn_r) pulses++;
        end
        check(pulses == 0, "R11 idle while run low", pulses, 0);
        idle(2);

        summary();
        $finish;
    end

endmodule